// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control for a five-stage in-order integer pipeline whose stages are fetch, decode with register read, execute, memory and writeback. It takes the register specifiers and control bits held in the pipeline registers and returns three things. The first is a 2-bit select code for each ALU operand multiplexer. The second is a front-end stall that holds the program counter and the fetch/decode register. The third is a pair of bubble controls: one turns the word entering the fetch/decode register into a no-op, the other does the same for the control bits entering the decode/execute register.

Three hazards are resolved. A read-after-write dependence on an instruction in execute/memory or memory/writeback is handled by forwarding. The younger producer wins when both match. A load directly followed by a reader of its destination costs one cycle: the front end is held and a no-op is placed into decode/execute, after which the loaded value is forwarded from memory/writeback. When the shared instruction/data memory is busy with a data access in the memory stage, fetch stalls and a no-op enters the fetch/decode register. Register zero never forwards. Sources are read only in decode and destinations are written only in writeback, so write-after-read and write-after-write cases cannot arise and are not detected. The register file must write in the first half of the cycle, or bypass into decode, so that a reader three instructions behind its producer needs no forwarding.

The logic is purely combinational. The clock and reset inputs exist only to clock the built-in checks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each operand select is 2 bits: 00 takes the register-file value, 10 takes the execute/memory result, 01 takes the memory/writeback result. The code 11 never appears.
- R2: An operand whose execute-stage source specifier equals the execute/memory destination selects 10 when that producer's write enable is set and its destination is nonzero.
- R3: An operand that matches the memory/writeback destination (write enable set, destination nonzero) but has no valid execute/memory match selects 01. When both sources match, 10 is chosen.
- R4: A producer with write enable clear, or with destination register zero, is never forwarded. An operand with no valid match selects 00.
- R5: When the instruction in execute is a load with write enable set and a nonzero destination, and a source that decode actually reads equals that destination, the outputs are pc_hold=1, ifid_hold=1 and idex_flush=1.
- R6: A load in execute causes no stall when decode does not read its destination: the matching use bit is clear, the specifiers differ, or the destination is zero.
- R7: When the memory stage performs a data access and no load-use stall is present, the outputs are pc_hold=1, ifid_flush=1, ifid_hold=0 and idex_flush=0.
- R8: When a load-use stall and a data access occur together, the load-use response wins: pc_hold=1, ifid_hold=1, idex_flush=1 and ifid_flush=0.
- R9: With no load-use stall and no data access, all four front-end controls are 0. This includes a non-load producer in execute whose destination matches a decode source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset; disables the checks |
| id_rs1 | input | RA_W | First source specifier of the instruction in decode |
| id_rs2 | input | RA_W | Second source specifier of the instruction in decode |
| id_rs1_rd | input | 1 | Decode instruction reads its first source |
| id_rs2_rd | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | RA_W | First source specifier held in decode/execute |
| ex_rs2 | input | RA_W | Second source specifier held in decode/execute |
| ex_rd | input | RA_W | Destination specifier held in decode/execute |
| ex_wen | input | 1 | Register write enable held in decode/execute |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | RA_W | Destination specifier in execute/memory |
| mem_wen | input | 1 | Register write enable in execute/memory |
| mem_dacc | input | 1 | Memory stage uses the shared memory for data |
| wb_rd | input | RA_W | Destination specifier in memory/writeback |
| wb_wen | input | 1 | Register write enable in memory/writeback |
| fwd_a | output | 2 | Select code for the first ALU operand |
| fwd_b | output | 2 | Select code for the second ALU operand |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Load a no-op into the fetch/decode register |
| idex_flush | output | 1 | Clear the control bits entering decode/execute |

## Verification
The assertions assume only that the inputs are settled, known values at each sampled edge. They take no ordering between stages for granted, so every combination of specifiers and control bits is legal for them, including a load with its write enable clear. The stimulus sweeps every combination in a 2-bit register-specifier configuration and changes inputs only on the falling edge. Each rising edge therefore sees a complete, stable vector, and no pipeline-consistency assumption is needed.

// File: rtl/hz_pkg.sv
// Shared types for the hazard controller.
// Assumes nothing beyond a 2-bit select field on each ALU operand mux.
package hz_pkg;

    // Operand multiplexer select codes; 2'b11 is never produced.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_MWB = 2'b01,
        SEL_EXM = 2'b10
    } opnd_sel_e;

endpackage

// File: rtl/hz_opnd_fwd.sv
// Forwarding selector for one ALU operand.
// Compares the operand's source specifier with the two downstream
// producers and prefers the younger one (execute/memory).
// Assumes register zero is hard-wired and must never be forwarded.
module hz_opnd_fwd
    import hz_pkg::*;
#(
    parameter int RA_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] rs,
    input  logic [RA_W-1:0] exm_rd,
    input  logic            exm_we,
    input  logic [RA_W-1:0] mwb_rd,
    input  logic            mwb_we,
    output opnd_sel_e       sel
);

    localparam logic [RA_W-1:0] REG_ZERO = '0;

    logic exm_hit;
    logic mwb_hit;

    // Valid producer matches for this operand.
    assign exm_hit = exm_we && (exm_rd != REG_ZERO) && (exm_rd == rs);
    assign mwb_hit = mwb_we && (mwb_rd != REG_ZERO) && (mwb_rd == rs);

    // Priority pick: younger producer first, then older, else register file.
    always_comb begin
        if (exm_hit) begin
            sel = SEL_EXM;
        end else if (mwb_hit) begin
            sel = SEL_MWB;
        end else begin
            sel = SEL_RF;
        end
    end

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'b11); // R1
    AST_SEL_NOT_R0: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_RF) |-> (rs != REG_ZERO)); // R4
    AST_EXM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_EXM) |-> (exm_we && exm_rd == rs)); // R2
    AST_MWB_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MWB) |-> !(exm_we && exm_rd == rs && rs != REG_ZERO)); // R3

endmodule

// File: rtl/hz_load_use.sv
// Load-use detector.
// Flags a load in execute whose destination is read by the decode
// instruction. Assumes the use bits are zero for unused source fields.
module hz_load_use #(
    parameter int RA_W    = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0][RA_W-1:0]  id_rs,
    input  logic [NUM_SRC-1:0]            id_use,
    input  logic [RA_W-1:0]               ex_rd,
    input  logic                          ex_we,
    input  logic                          ex_load,
    output logic                          lu_stall
);

    localparam logic [RA_W-1:0] REG_ZERO = '0;

    logic [NUM_SRC-1:0] src_hit;

    // Per-source comparison against the load destination.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_hit[i] = id_use[i] && (id_rs[i] == ex_rd);
    end

    // Stall only for a real register-writing load that feeds decode.
    assign lu_stall = ex_load && ex_we && (ex_rd != REG_ZERO) && (|src_hit);

    AST_LU_HAS_READER: assert property (@(posedge clk) disable iff (!rst_n)
        lu_stall |-> ($countones(id_use) > 0)); // R6
    AST_LU_NOT_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !lu_stall); // R9

endmodule

// File: rtl/hz_front_ctrl.sv
// Front-end stall and bubble arbiter.
// Combines the load-use stall with the shared-memory fetch conflict.
// Load-use has priority on the fetch/decode register, because the
// decode instruction must be kept rather than replaced by a no-op.
module hz_front_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lu_stall,
    input  logic dmem_busy,
    output logic pc_hold,
    output logic ifid_hold,
    output logic ifid_flush,
    output logic idex_flush
);

    // Priority-resolved front-end controls.
    always_comb begin
        pc_hold    = lu_stall || dmem_busy;
        ifid_hold  = lu_stall;
        ifid_flush = dmem_busy && !lu_stall;
        idex_flush = lu_stall;
    end

    AST_HOLD_XOR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifid_hold && ifid_flush)); // R8
    AST_BUBBLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_flush || idex_flush) |-> pc_hold); // R7
    AST_QUIET_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lu_stall && !dmem_busy) |-> !(pc_hold || ifid_flush || idex_flush)); // R9
    AST_LU_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        lu_stall |-> (pc_hold && ifid_hold && idex_flush)); // R5

endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard and forwarding controller for a five-stage in-order pipeline.
// Produces ALU operand select codes and front-end stall/bubble
// controls. Assumes reads happen only in decode and writes only in
// writeback, and that the register file writes in the first half-cycle.
module pipe_hazard_ctrl
    import hz_pkg::*;
#(
    parameter int RA_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] id_rs1,
    input  logic [RA_W-1:0] id_rs2,
    input  logic            id_rs1_rd,
    input  logic            id_rs2_rd,
    input  logic [RA_W-1:0] ex_rs1,
    input  logic [RA_W-1:0] ex_rs2,
    input  logic [RA_W-1:0] ex_rd,
    input  logic            ex_wen,
    input  logic            ex_load,
    input  logic [RA_W-1:0] mem_rd,
    input  logic            mem_wen,
    input  logic            mem_dacc,
    input  logic [RA_W-1:0] wb_rd,
    input  logic            wb_wen,
    output logic [1:0]      fwd_a,
    output logic [1:0]      fwd_b,
    output logic            pc_hold,
    output logic            ifid_hold,
    output logic            ifid_flush,
    output logic            idex_flush
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][RA_W-1:0] ex_src;
    logic [NUM_SRC-1:0][RA_W-1:0] id_src;
    logic [NUM_SRC-1:0]           id_use;
    opnd_sel_e                    sel [NUM_SRC];
    logic                         lu_stall;

    // Gather the per-operand fields into indexed vectors.
    assign ex_src = {ex_rs2, ex_rs1};
    assign id_src = {id_rs2, id_rs1};
    assign id_use = {id_rs2_rd, id_rs1_rd};

    // One forwarding selector per ALU operand.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
        hz_opnd_fwd #(.RA_W(RA_W)) u_fwd (
            .clk    (clk),
            .rst_n  (rst_n),
            .rs     (ex_src[i]),
            .exm_rd (mem_rd),
            .exm_we (mem_wen),
            .mwb_rd (wb_rd),
            .mwb_we (wb_wen),
            .sel    (sel[i])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    hz_load_use #(.RA_W(RA_W), .NUM_SRC(NUM_SRC)) u_lu (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_rs    (id_src),
        .id_use   (id_use),
        .ex_rd    (ex_rd),
        .ex_we    (ex_wen),
        .ex_load  (ex_load),
        .lu_stall (lu_stall)
    );

    hz_front_ctrl u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .lu_stall   (lu_stall),
        .dmem_busy  (mem_dacc),
        .pc_hold    (pc_hold),
        .ifid_hold  (ifid_hold),
        .ifid_flush (ifid_flush),
        .idex_flush (idex_flush)
    );

    AST_DACC_STALLS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dacc |-> pc_hold); // R7

endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;

    localparam int RW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
    logic [RW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic id_rs1_rd = 0, id_rs2_rd = 0, ex_wen = 0, ex_load = 0;
    logic mem_wen = 0, mem_dacc = 0, wb_wen = 0;
    logic [1:0] fwd_a, fwd_b;
    logic pc_hold, ifid_hold, ifid_flush, idex_flush;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pipe_hazard_ctrl #(.RA_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_rd(id_rs1_rd), .id_rs2_rd(id_rs2_rd),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_dacc(mem_dacc),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Expected select code from R1-style encoding: 10 younger, 01 older, 00 file.
    function automatic logic [1:0] exp_sel(input logic [RW-1:0] rs,
            input logic [RW-1:0] mr, input logic mw,
            input logic [RW-1:0] wr, input logic ww);
        if (mw && mr != 0 && mr == rs) return 2'b10;
        if (ww && wr != 0 && wr == rs) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_req(input logic [1:0] e,
            input logic [RW-1:0] rs, input logic [RW-1:0] mr, input logic mw);
        if (e == 2'b10) return "R2";
        if (e == 2'b01) return "R3";
        if (mw && mr == rs) return "R4";
        return "R1";
    endfunction

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // Reset state: all-zero inputs give file selects and no stall (R9).
        check("R9", {2'b00, fwd_a}, 4'b0000);
        check("R9", {2'b00, fwd_b}, 4'b0000);
        check("R9", {pc_hold, ifid_hold, ifid_flush, idex_flush}, 4'b0000);
        rst_n = 1'b1;

        // Forwarding sweep: ex_rs1, ex_rs2, mem_rd, mem_wen, wb_rd, wb_wen.
        for (int v = 0; v < 1024; v++) begin
            logic [9:0] b;
            logic [1:0] ea, eb;
            @(negedge clk);
            b = v[9:0];
            ex_rs1 = b[1:0]; ex_rs2 = b[3:2]; mem_rd = b[5:4];
            mem_wen = b[6]; wb_rd = b[8:7]; wb_wen = b[9];
            #1;
            ea = exp_sel(ex_rs1, mem_rd, mem_wen, wb_rd, wb_wen);
            eb = exp_sel(ex_rs2, mem_rd, mem_wen, wb_rd, wb_wen);
            check(sel_req(ea, ex_rs1, mem_rd, mem_wen), {2'b00, fwd_a}, {2'b00, ea});
            check(sel_req(eb, ex_rs2, mem_rd, mem_wen), {2'b00, fwd_b}, {2'b00, eb});
        end

        // Hazard sweep: id_rs1, id_rs2, use bits, ex_rd, ex_wen, ex_load, mem_dacc.
        for (int v = 0; v < 2048; v++) begin
            logic [10:0] b;
            logic lu;
            logic [3:0] e;
            string rq;
            @(negedge clk);
            b = v[10:0];
            id_rs1 = b[1:0]; id_rs2 = b[3:2]; id_rs1_rd = b[4]; id_rs2_rd = b[5];
            ex_rd = b[7:6]; ex_wen = b[8]; ex_load = b[9]; mem_dacc = b[10];
            #1;
            lu = ex_load && ex_wen && ex_rd != 0 &&
                 ((id_rs1_rd && id_rs1 == ex_rd) || (id_rs2_rd && id_rs2 == ex_rd));
            // Order {pc_hold, ifid_hold, ifid_flush, idex_flush}.
            if (lu && mem_dacc) begin e = 4'b1101; rq = "R8"; end
            else if (lu)        begin e = 4'b1101; rq = "R5"; end
            else if (mem_dacc)  begin e = 4'b1010; rq = "R7"; end
            else if (ex_load)   begin e = 4'b0000; rq = "R6"; end
            else                begin e = 4'b0000; rq = "R9"; end
            check(rq, {pc_hold, ifid_hold, ifid_flush, idex_flush}, e);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule